// File: doc/BRIEF.md
# Fuse Programming Unlock Controller

This block guards the one-time programming of a bank of protection fuses. Programming is only possible while an active-low strap pin is pulled low, and for as long as that pin is low the rest of the device is held off through a run-inhibit output. To leave reset and run normally, the board keeps the strap high.

Once the strap is low, a host must clock in a long secret key on a serial clock/data pair. Each bit is compared as it arrives. A single wrong bit, or an unknown command, drops the controller into a lockout. The only way out of lockout is to release the strap and assert it again. After a correct key, a 4-bit command either burns one indexed fuse or burns every protection fuse at once. Burning every fuse leaves the device permanently unable to be locked.

A burn is a fixed-length strobe to the fuse cells. The cells themselves are modelled as sticky register bits, which the bench can observe.

Top module: `fuse_unlock_top`

## Requirements
- R1: `runInhibit` is 0 after reset. It rises exactly SYNC_STAGES+1 (default 3) clock edges after `progEnN` goes low, and falls the same number of edges after `progEnN` returns high.
- R2: `burnStrobe` is zero while `runInhibit` is low. Releasing the strap never leaves a strobe running.
- R3: The key is KEY_WIDTH (64) bits, default 64'hA5C3_1E7B_96F0_4D28. It is sent MSB first, one bit per rising edge of `serClk`, with `serData` as the value.
- R4: A wrong key bit at any position causes lockout. After lockout, no fuse burns during that strap session, even if a complete correct sequence is sent afterwards, and `runInhibit` stays high.
- R5: Releasing the strap and asserting it again clears lockout, so a new correct attempt succeeds.
- R6: Command 4'h6, sent MSB first after the key, is followed by a 3-bit fuse index sent MSB first. It strobes and sets only that fuse (bit position = index).
- R7: Command 4'h9 strobes and sets all NUM_FUSES (8) fuses together.
- R8: Any other command value causes lockout with no burn.
- R9: A burn strobe lasts exactly BURN_CYCLES (16) clock cycles, and its value is constant for the whole burn.
- R10: `fuseState` is 0 after reset. A bit sets only at the end of a completed strobe on that bit, is never cleared afterwards, and later burns add to earlier ones.
- R11: Releasing the strap during a burn stops the strobe and leaves `fuseState` unchanged.
- R12: After a completed burn, further serial traffic is ignored until the strap is cycled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset; also clears the fuse model |
| progEnN | input | 1 | Active-low programming strap |
| serClk | input | 1 | Serial key clock; bits are taken on its rising edge |
| serData | input | 1 | Serial key data |
| runInhibit | output | 1 | High while the programming session holds normal operation off |
| burnStrobe | output | NUM_FUSES | Burn pulse to each fuse cell |
| fuseState | output | NUM_FUSES | Sticky model of the blown fuses |

## Verification
A controller stuck in the wrong state shows up as a missing burn, a burn of the wrong fuse, or a burn that should not happen. Each of these is visible on `burnStrobe` within about five clocks of the final serial rising edge, and on `fuseState` sixteen cycles later. A key comparator or lockout that fails to stick shows up when a retry in the same strap session produces a burn. A faulty release path shows up as `runInhibit` still high, or a strobe still running, more than three cycles after the strap goes high.

// File: rtl/fuse_unlock_pkg.sv
package fuse_unlock_pkg;
  localparam int CMD_W = 4;
  localparam logic [CMD_W-1:0] CMD_BLOW_ONE = 4'h6;
  localparam logic [CMD_W-1:0] CMD_BLOW_ALL = 4'h9;

  typedef enum logic [2:0] {
    ST_IDLE, ST_KEY, ST_CMD, ST_INDEX, ST_ARM, ST_BURN, ST_DONE, ST_LOCK
  } unlockState_e;

  typedef struct packed {
    logic clrCnt;     // restart field counter, reload key reference
    logic takeBit;    // advance field counter and key reference
    logic shiftCmd;
    logic shiftIdx;
    logic startBurn;  // latch burn mask, load burn timer
    logic burning;
    logic commit;     // write burn mask into fuse model
  } unlockCtl_t;
endpackage

// File: rtl/fuse_unlock_dp.sv
module fuse_unlock_dp
  import fuse_unlock_pkg::*;
#(
  parameter int KEY_WIDTH = 64,
  parameter logic [KEY_WIDTH-1:0] KEY_VALUE = 64'hA5C3_1E7B_96F0_4D28,
  parameter int NUM_FUSES = 8,
  parameter int BURN_CYCLES = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic progEnN,
  input  logic serClk,
  input  logic serData,
  input  unlockCtl_t ctl,
  output logic enActive,
  output logic bitStrobe,
  output logic keyBitOk,
  output logic lastKeyBit,
  output logic lastCmdBit,
  output logic lastIdxBit,
  output logic [CMD_W-1:0] cmdNext,
  output logic burnLast,
  output logic [NUM_FUSES-1:0] burnStrobe,
  output logic [NUM_FUSES-1:0] fuseState
);
  localparam int IDX_W = (NUM_FUSES > 1) ? $clog2(NUM_FUSES) : 1;
  localparam int CNT_W = $clog2(KEY_WIDTH);
  localparam int BT_W  = $clog2(BURN_CYCLES + 1);

  logic enSync, clkSync, datSync, clkPrev;

  // input synchronisers; stage count picks the structure
  if (SYNC_STAGES == 1) begin : g_syncOne
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enSync  <= 1'b1;
        clkSync <= 1'b0;
        datSync <= 1'b0;
      end else begin
        enSync  <= progEnN;
        clkSync <= serClk;
        datSync <= serData;
      end
    end
  end else begin : g_syncChain
    logic [SYNC_STAGES-1:0] enPipe, clkPipe, datPipe;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enPipe  <= '1;
        clkPipe <= '0;
        datPipe <= '0;
      end else begin
        enPipe  <= {enPipe[SYNC_STAGES-2:0], progEnN};
        clkPipe <= {clkPipe[SYNC_STAGES-2:0], serClk};
        datPipe <= {datPipe[SYNC_STAGES-2:0], serData};
      end
    end
    assign enSync  = enPipe[SYNC_STAGES-1];
    assign clkSync = clkPipe[SYNC_STAGES-1];
    assign datSync = datPipe[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) clkPrev <= 1'b0;
    else       clkPrev <= clkSync;
  end

  assign enActive  = ~enSync;
  assign bitStrobe = clkSync & ~clkPrev;

  // field counter and key reference
  logic [CNT_W-1:0] bitCnt;
  logic [KEY_WIDTH-1:0] keyRef;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      keyRef <= KEY_VALUE;
    end else if (ctl.clrCnt) begin
      bitCnt <= '0;
      keyRef <= KEY_VALUE;
    end else if (ctl.takeBit) begin
      bitCnt <= bitCnt + 1'b1;
      keyRef <= {keyRef[KEY_WIDTH-2:0], 1'b0};
    end
  end

  assign keyBitOk   = (datSync == keyRef[KEY_WIDTH-1]);
  assign lastKeyBit = (bitCnt == CNT_W'(KEY_WIDTH - 1));
  assign lastCmdBit = (bitCnt == CNT_W'(CMD_W - 1));
  assign lastIdxBit = (bitCnt == CNT_W'(IDX_W - 1));

  // command and index shifters
  logic [CMD_W-1:0] cmdReg;
  logic [IDX_W-1:0] idxReg;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg <= '0;
      idxReg <= '0;
    end else begin
      if (ctl.shiftCmd) cmdReg <= cmdNext;
      if (ctl.shiftIdx) idxReg <= (idxReg << 1) | IDX_W'(datSync);
    end
  end
  assign cmdNext = (cmdReg << 1) | CMD_W'(datSync);

  // fuse selection
  logic [NUM_FUSES-1:0] selMask;
  always_comb begin
    for (int i = 0; i < NUM_FUSES; i++) begin
      selMask[i] = (idxReg == IDX_W'(i));
    end
  end

  logic [NUM_FUSES-1:0] burnMask;
  logic [BT_W-1:0] burnCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burnMask <= '0;
      burnCnt  <= '0;
    end else if (ctl.startBurn) begin
      burnMask <= (cmdReg == CMD_BLOW_ALL) ? '1 : selMask;
      burnCnt  <= BT_W'(BURN_CYCLES - 1);
    end else if (ctl.burning && burnCnt != '0) begin
      burnCnt <= burnCnt - 1'b1;
    end
  end
  assign burnLast   = (burnCnt == '0);
  assign burnStrobe = ctl.burning ? burnMask : '0;

  // sticky fuse model
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           fuseState <= '0;
    else if (ctl.commit) fuseState <= fuseState | burnMask;
  end
endmodule

// File: rtl/fuse_unlock_ctrl.sv
module fuse_unlock_ctrl
  import fuse_unlock_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic enActive,
  input  logic bitStrobe,
  input  logic keyBitOk,
  input  logic lastKeyBit,
  input  logic lastCmdBit,
  input  logic lastIdxBit,
  input  logic [CMD_W-1:0] cmdNext,
  input  logic burnLast,
  output unlockCtl_t ctl,
  output logic runInhibit
);
  unlockState_e st, stNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= stNext;
  end

  always_comb begin
    stNext = st;
    ctl    = '0;
    if (!enActive) begin
      stNext = ST_IDLE;
    end else begin
      case (st)
        ST_IDLE: begin
          ctl.clrCnt = 1'b1;
          stNext     = ST_KEY;
        end
        ST_KEY: if (bitStrobe) begin
          if (!keyBitOk) begin
            stNext = ST_LOCK;
          end else if (lastKeyBit) begin
            ctl.clrCnt = 1'b1;
            stNext     = ST_CMD;
          end else begin
            ctl.takeBit = 1'b1;
          end
        end
        ST_CMD: if (bitStrobe) begin
          ctl.shiftCmd = 1'b1;
          if (!lastCmdBit) begin
            ctl.takeBit = 1'b1;
          end else if (cmdNext == CMD_BLOW_ONE) begin
            ctl.clrCnt = 1'b1;
            stNext     = ST_INDEX;
          end else if (cmdNext == CMD_BLOW_ALL) begin
            stNext = ST_ARM;
          end else begin
            stNext = ST_LOCK;
          end
        end
        ST_INDEX: if (bitStrobe) begin
          ctl.shiftIdx = 1'b1;
          if (lastIdxBit) stNext = ST_ARM;
          else            ctl.takeBit = 1'b1;
        end
        ST_ARM: begin
          ctl.startBurn = 1'b1;
          stNext        = ST_BURN;
        end
        ST_BURN: begin
          ctl.burning = 1'b1;
          if (burnLast) begin
            ctl.commit = 1'b1;
            stNext     = ST_DONE;
          end
        end
        ST_DONE, ST_LOCK: stNext = st;
        default: stNext = ST_IDLE;
      endcase
    end
  end

  assign runInhibit = (st != ST_IDLE);
endmodule

// File: rtl/fuse_unlock_top.sv
module fuse_unlock_top
  import fuse_unlock_pkg::*;
#(
  parameter int KEY_WIDTH = 64,
  parameter logic [KEY_WIDTH-1:0] KEY_VALUE = 64'hA5C3_1E7B_96F0_4D28,
  parameter int NUM_FUSES = 8,
  parameter int BURN_CYCLES = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic progEnN,
  input  logic serClk,
  input  logic serData,
  output logic runInhibit,
  output logic [NUM_FUSES-1:0] burnStrobe,
  output logic [NUM_FUSES-1:0] fuseState
);
  unlockCtl_t ctl;
  logic enActive, bitStrobe, keyBitOk, lastKeyBit, lastCmdBit, lastIdxBit, burnLast;
  logic [CMD_W-1:0] cmdNext;

  fuse_unlock_dp #(
    .KEY_WIDTH(KEY_WIDTH), .KEY_VALUE(KEY_VALUE), .NUM_FUSES(NUM_FUSES),
    .BURN_CYCLES(BURN_CYCLES), .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .clk(clk), .rstN(rstN), .progEnN(progEnN), .serClk(serClk), .serData(serData),
    .ctl(ctl), .enActive(enActive), .bitStrobe(bitStrobe), .keyBitOk(keyBitOk),
    .lastKeyBit(lastKeyBit), .lastCmdBit(lastCmdBit), .lastIdxBit(lastIdxBit),
    .cmdNext(cmdNext), .burnLast(burnLast), .burnStrobe(burnStrobe),
    .fuseState(fuseState)
  );

  fuse_unlock_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .enActive(enActive), .bitStrobe(bitStrobe),
    .keyBitOk(keyBitOk), .lastKeyBit(lastKeyBit), .lastCmdBit(lastCmdBit),
    .lastIdxBit(lastIdxBit), .cmdNext(cmdNext), .burnLast(burnLast),
    .ctl(ctl), .runInhibit(runInhibit)
  );
endmodule

// File: rtl/fuse_unlock_chk.sv
module fuse_unlock_chk #(
  parameter int NUM_FUSES = 8,
  parameter int BURN_CYCLES = 16,
  parameter int SYNC_STAGES = 2
) (
  input logic clk,
  input logic rstN,
  input logic progEnN,
  input logic runInhibit,
  input logic [NUM_FUSES-1:0] burnStrobe,
  input logic [NUM_FUSES-1:0] fuseState
);
  int unsigned highCnt, lowCnt, runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      highCnt <= 0;
      lowCnt  <= 0;
      runCnt  <= 0;
    end else begin
      if (progEnN) begin
        lowCnt <= 0;
        if (highCnt <= SYNC_STAGES) highCnt <= highCnt + 1;
      end else begin
        highCnt <= 0;
        if (lowCnt <= SYNC_STAGES) lowCnt <= lowCnt + 1;
      end
      runCnt <= (burnStrobe != '0) ? runCnt + 1 : 0;
    end
  end

  // R1: inhibit follows the strap after the synchroniser delay
  assert_inhibit_release_R1: assert property (@(posedge clk) disable iff (!rstN)
    (highCnt > SYNC_STAGES) |-> !runInhibit);
  assert_inhibit_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    (lowCnt > SYNC_STAGES) |-> runInhibit);

  // R2: no strobe outside a programming session
  assert_strobe_in_session_R2: assert property (@(posedge clk) disable iff (!rstN)
    (burnStrobe != '0) |-> runInhibit);

  // R9: strobe never exceeds its length and keeps one value
  assert_strobe_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
    runCnt <= BURN_CYCLES);
  assert_strobe_steady_R9: assert property (@(posedge clk) disable iff (!rstN)
    (burnStrobe != '0 && $past(burnStrobe) != '0) |-> burnStrobe == $past(burnStrobe));

  // R10: fuse bits are sticky and only set after a full strobe on them
  assert_fuse_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    (fuseState & $past(fuseState)) == $past(fuseState));
  assert_fuse_needs_strobe_R10: assert property (@(posedge clk) disable iff (!rstN)
    (fuseState & ~$past(fuseState) & ~$past(burnStrobe)) == '0);
  assert_fuse_full_burn_R9: assert property (@(posedge clk) disable iff (!rstN)
    (fuseState != $past(fuseState)) |-> runCnt == BURN_CYCLES);
endmodule

bind fuse_unlock_top fuse_unlock_chk #(
  .NUM_FUSES(NUM_FUSES), .BURN_CYCLES(BURN_CYCLES), .SYNC_STAGES(SYNC_STAGES)
) chk_i (
  .clk(clk), .rstN(rstN), .progEnN(progEnN), .runInhibit(runInhibit),
  .burnStrobe(burnStrobe), .fuseState(fuseState)
);

// File: tb/fuse_unlock_tb.sv
module fuse_unlock_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] KEY = 64'hA5C3_1E7B_96F0_4D28;
  localparam logic [7:0] NO_FLIP = 8'hFF;
  localparam int BURN_LEN = 16;

  typedef struct packed {
    logic [7:0] flip;
    logic [3:0] cmd;
    logic [2:0] idx;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{NO_FLIP, 4'h6, 3'd2},   // R6 single fuse
    '{8'd0,    4'h6, 3'd5},   // R4 first key bit wrong
    '{8'd63,   4'h6, 3'd5},   // R4 last key bit wrong
    '{NO_FLIP, 4'h6, 3'd5},   // R5 retry after lockout
    '{NO_FLIP, 4'h3, 3'd1},   // R8 unknown command
    '{NO_FLIP, 4'h6, 3'd0},   // R10 accumulate
    '{8'd31,   4'h9, 3'd0},   // R4 mid key wrong
    '{NO_FLIP, 4'h9, 3'd0}    // R7 all fuses
  };

  logic clk = 1'b0;
  logic rstN, progEnN, serClk, serData;
  logic runInhibit;
  logic [7:0] burnStrobe, fuseState;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fuse_unlock_top dut_i (
    .clk(clk), .rstN(rstN), .progEnN(progEnN), .serClk(serClk), .serData(serData),
    .runInhibit(runInhibit), .burnStrobe(burnStrobe), .fuseState(fuseState)
  );

  // strobe monitor: burst count, length and value of the last burst
  int run = 0;
  int lastRun = 0;
  int burstCount = 0;
  logic [7:0] curMask = '0;
  logic [7:0] lastMask = '0;
  always @(negedge clk) begin
    if (burnStrobe != '0) begin
      if (run == 0) begin
        burstCount = burstCount + 1;
        curMask = burnStrobe;
      end
      run = run + 1;
    end else if (run != 0) begin
      lastRun = run;
      lastMask = curMask;
      run = 0;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sendBit(input logic b);
    serData = b;
    repeat (2) @(negedge clk);
    serClk = 1'b1;
    repeat (3) @(negedge clk);
    serClk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic sendSeq(input logic [7:0] flip, input logic [3:0] cmd, input logic [2:0] idx);
    for (int i = 0; i < 64; i++) sendBit(KEY[63-i] ^ (flip == 8'(i)));
    for (int i = 3; i >= 0; i--) sendBit(cmd[i]);
    if (cmd == 4'h6) for (int i = 2; i >= 0; i--) sendBit(idx[i]);
  endtask

  task automatic beginSession();
    @(negedge clk);
    progEnN = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic endSession();
    progEnN = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0; progEnN = 1'b1; serClk = 1'b0; serData = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] expFuse;
    logic [7:0] expBurn;
    int b0;

    doReset();
    check(runInhibit == 1'b0, "R1 reset inhibit", 64'(runInhibit), 64'd0);
    check(burnStrobe == '0, "R2 reset strobe", 64'(burnStrobe), 64'd0);
    check(fuseState == '0, "R10 reset fuses", 64'(fuseState), 64'd0);

    // R1 exact latency of the inhibit
    progEnN = 1'b0;
    repeat (2) @(negedge clk);
    check(runInhibit == 1'b0, "R1 inhibit not yet", 64'(runInhibit), 64'd0);
    @(negedge clk);
    check(runInhibit == 1'b1, "R1 inhibit on", 64'(runInhibit), 64'd1);
    progEnN = 1'b1;
    repeat (2) @(negedge clk);
    check(runInhibit == 1'b1, "R1 inhibit still on", 64'(runInhibit), 64'd1);
    @(negedge clk);
    check(runInhibit == 1'b0, "R1 inhibit off", 64'(runInhibit), 64'd0);
    repeat (4) @(negedge clk);

    // vector table (R3..R8, R10)
    expFuse = '0;
    for (int v = 0; v < NVEC; v++) begin
      expBurn = '0;
      if (VECS[v].flip == NO_FLIP) begin
        if (VECS[v].cmd == 4'h6)      expBurn = 8'(1) << VECS[v].idx;
        else if (VECS[v].cmd == 4'h9) expBurn = 8'hFF;
      end
      b0 = burstCount;
      beginSession();
      sendSeq(VECS[v].flip, VECS[v].cmd, VECS[v].idx);
      repeat (30) @(negedge clk);
      check(burstCount - b0 == ((expBurn != '0) ? 1 : 0), $sformatf("R3 vec%0d burst count", v),
            64'(burstCount - b0), 64'((expBurn != '0) ? 1 : 0));
      if (expBurn != '0) begin
        check(lastMask == expBurn, $sformatf("R6 R7 vec%0d strobe mask", v),
              64'(lastMask), 64'(expBurn));
        check(lastRun == BURN_LEN, $sformatf("R9 vec%0d strobe length", v),
              64'(lastRun), 64'(BURN_LEN));
      end
      expFuse = expFuse | expBurn;
      check(fuseState == expFuse, $sformatf("R10 vec%0d fuse state", v),
            64'(fuseState), 64'(expFuse));
      endSession();
    end

    // directed: single burn, then R12 ignore after done
    doReset();
    beginSession();
    sendSeq(NO_FLIP, 4'h6, 3'd7);
    repeat (30) @(negedge clk);
    check(lastMask == 8'h80, "R6 top index mask", 64'(lastMask), 64'h80);
    check(lastRun == BURN_LEN, "R9 top index length", 64'(lastRun), 64'(BURN_LEN));
    b0 = burstCount;
    sendSeq(NO_FLIP, 4'h6, 3'd1);
    repeat (30) @(negedge clk);
    check(burstCount == b0, "R12 no second burn", 64'(burstCount - b0), 64'd0);
    check(fuseState == 8'h80, "R12 fuses unchanged", 64'(fuseState), 64'h80);
    endSession();

    // R4: lockout persists through a correct retry in the same session
    beginSession();
    b0 = burstCount;
    sendSeq(8'd40, 4'h6, 3'd2);
    sendSeq(NO_FLIP, 4'h6, 3'd2);
    repeat (30) @(negedge clk);
    check(burstCount == b0, "R4 locked retry", 64'(burstCount - b0), 64'd0);
    check(fuseState == 8'h80, "R4 fuses unchanged", 64'(fuseState), 64'h80);
    check(runInhibit == 1'b1, "R4 inhibit in lockout", 64'(runInhibit), 64'd1);
    endSession();

    // R11: strap released mid-burn
    beginSession();
    sendSeq(NO_FLIP, 4'h6, 3'd3);
    for (int w = 0; w < 60 && burnStrobe == '0; w++) @(negedge clk);
    check(burnStrobe == 8'h08, "R11 burn started", 64'(burnStrobe), 64'h08);
    repeat (5) @(negedge clk);
    progEnN = 1'b1;
    repeat (4) @(negedge clk);
    check(burnStrobe == '0, "R11 strobe stopped", 64'(burnStrobe), 64'd0);
    check(runInhibit == 1'b0, "R11 inhibit released", 64'(runInhibit), 64'd0);
    check(lastRun < BURN_LEN, "R11 short burst", 64'(lastRun), 64'(BURN_LEN - 1));
    repeat (30) @(negedge clk);
    check(fuseState == 8'h80, "R11 fuse not set", 64'(fuseState), 64'h80);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule